// File: doc/BRIEF.md
# Watchdog Timer with Selectable Post-Divider

The block is a watchdog that runs from a slow, free-running tick. That tick reaches it as a one-cycle enable in the system clock domain. Each tick advances a chain of counters:

- a unit stage of `UNIT_TICKS` ticks,
- a fixed divide-by-8 base stage,
- a post-divider whose ratio comes from a 3-bit field.

When the selected count runs out, the block sends out a one-cycle reset request. Software keeps the device alive by writing a one to the kick bit before that point. The kick clears every stage at once.

The 3-bit ratio field is shared with a general-purpose timer's mode register, so the watchdog decodes it in inverted form. Code `111` gives the shortest timeout and `000` the longest. `000` is also the value that field holds after power-up. A static enable input switches the watchdog off for good when it is low. The count does not stop in stop mode. An expiry while the stop flag is high also raises a wake request alongside the reset request.

Top module: `slow_watchdog`

## Requirements
- R1: The ratio field selects the post-division: code 111→1, 110→2, 101→4, 100→8, 011→32, 010→128, 001→512, 000→2048. Counting from a cleared state, the expiry falls on exactly tick number `UNIT_TICKS*8*ratio`, where a tick is a cycle with `slow_tick` high.
- R2: While `rst_n` is low, `rst_req` and `wake_req` are low. After release, the count starts from zero, so the first expiry falls on tick number `UNIT_TICKS*8*ratio`.
- R3: `rst_req` is high for exactly one cycle per expiry. The count restarts from zero, so the next expiry comes after another full period of ticks.
- R4: A cycle with `kick` high clears all counting stages. The next expiry falls on tick number `UNIT_TICKS*8*ratio` counted after the kick. A low `kick` has no effect.
- R5: A kick takes priority over any tick in the same cycle, including the tick that would have expired. No `rst_req` follows, and that tick is not counted.
- R6: A change of `ratio_sel` does not clear the count. The new ratio applies at the next base-period boundary. If the post count has already reached the new limit, expiry occurs at that boundary.
- R7: While `wd_on` is low, nothing counts, `rst_req` and `wake_req` stay low, and `kick` is ignored. When `wd_on` returns high, counting restarts from zero.
- R8: Counting is the same whether or not `stop_mode` is high. An expiry on a tick with `stop_mode` high raises `wake_req` in the same cycle as `rst_req`. With `stop_mode` low, `wake_req` stays low.
- R9: Only cycles with `slow_tick` high advance the count. Idle cycles between ticks do not change the expiry tick number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slow_tick | input | 1 | One-cycle enable from the slow free-running tick source |
| wd_on | input | 1 | Static enable; low disables the watchdog |
| kick | input | 1 | Strobe: a one clears the count and prescaler |
| ratio_sel | input | 3 | Shared ratio field, inverted code (111 shortest, 000 longest) |
| stop_mode | input | 1 | High while the device is in stop mode |
| rst_req | output | 1 | One-cycle reset request on expiry |
| wake_req | output | 1 | One-cycle wake request on expiry during stop mode |

## Verification
Both outputs are registered. A pulse caused by a tick consumed at one clock edge is therefore visible for exactly the cycle after that edge. The bench drives inputs on falling edges and samples on falling edges.

When the driver issues the tick that should expire, it enqueues the expected cycle number, which is its own cycle count plus one, together with the expected wake flag. The monitor compares every pulse it sees against the head of the queue. It reports a pulse with no queued expectation as unexpected, and a queued cycle that passes with no pulse as missing. Windows in which no pulse may occur (R5, R7) are therefore checked on every cycle.

// File: rtl/swd_pkg.sv
// Package: shared constants and the ratio-field decode for the watchdog.
// Assumes the 3-bit ratio field uses the inverted code (111 shortest).
package swd_pkg;

    localparam int RATIO_W = 3;
    localparam int MAX_SHIFT = 11;          // longest post ratio is 2**11
    localparam int POST_W = MAX_SHIFT;      // post counter reaches 2**11-1
    localparam int SHIFT_W = 4;

    // Map the inverted ratio code to a log2 post-division amount.
    // Inverted value v: 0..3 -> shift v, 4..7 -> shift 2v-3 (5,7,9,11).
    function automatic logic [SHIFT_W-1:0] ratio_shift(input logic [RATIO_W-1:0] code);
        logic [RATIO_W-1:0] v;
        logic [SHIFT_W-1:0] w;
        v = ~code;
        w = {1'b0, v};
        if (v[2]) begin
            return (w << 1) - 4'd3;
        end
        return w;
    endfunction

endpackage

// File: rtl/swd_stage_div.sv
// Module: one divide-by-DIV stage of the watchdog prescaler chain.
// Counts step pulses and emits a pulse on the step that wraps the count.
// Assumes DIV >= 2; a synchronous clear has priority over counting.
module swd_stage_div #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic pulse
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    // Decode the wrap point and the outgoing pulse.
    always_comb begin
        wrap  = (cnt == LAST);
        pulse = step & wrap;
    end

    // Advance the stage count on each step, clearing on reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/swd_post_cnt.sv
// Module: post-divider counter that decides watchdog expiry.
// Counts base-period pulses against a limit of 2**shift. The compare is
// ">= limit-1", so a ratio lowered mid-run takes effect at the next base
// pulse without clearing the count. Clear blocks expiry in its own cycle.
module swd_post_cnt
    import swd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               step,
    input  logic [SHIFT_W-1:0] shift,
    output logic               expire
);
    logic [POST_W-1:0] cnt;
    logic [POST_W:0]   lim_m1;
    logic              hit;

    // Form the limit from the decoded shift and compare the count against it.
    always_comb begin
        lim_m1 = ({{POST_W{1'b0}}, 1'b1} << shift) - 1'b1;
        hit    = ({1'b0, cnt} >= lim_m1);
        expire = step & hit & ~clr;
    end

    // Count base pulses; restart from zero on expiry, clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= hit ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/slow_watchdog.sv
// Module: watchdog timer driven by a slow tick enable.
// Chain: unit stage (UNIT_TICKS ticks) -> base stage (BASE_DIV) -> post
// divider selected by the inverted ratio field. Expiry gives a registered
// one-cycle reset request, and a wake request when stop mode is high.
// Assumes wd_on is static in normal use and slow_tick is a one-cycle strobe.
module slow_watchdog
    import swd_pkg::*;
#(
    parameter int UNIT_TICKS = 4,
    parameter int BASE_DIV   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slow_tick,
    input  logic               wd_on,
    input  logic               kick,
    input  logic [RATIO_W-1:0] ratio_sel,
    input  logic               stop_mode,
    output logic               rst_req,
    output logic               wake_req
);
    logic               clr;
    logic               tick_q;
    logic               unit_p;
    logic               base_p;
    logic               expire;
    logic [SHIFT_W-1:0] shift;
    logic               rst_q;
    logic               wake_q;

    // Qualify ticks by the enable; kick or disable clears all stages.
    always_comb begin
        clr    = kick | ~wd_on;
        tick_q = slow_tick & wd_on;
        shift  = ratio_shift(ratio_sel);
    end

    generate
        if (UNIT_TICKS > 1) begin : g_unit
            swd_stage_div #(.DIV(UNIT_TICKS)) u_unit (
                .clk  (clk),
                .rst_n(rst_n),
                .clr  (clr),
                .step (tick_q),
                .pulse(unit_p)
            );
        end else begin : g_unit_bypass
            assign unit_p = tick_q;
        end

        if (BASE_DIV > 1) begin : g_base
            swd_stage_div #(.DIV(BASE_DIV)) u_base (
                .clk  (clk),
                .rst_n(rst_n),
                .clr  (clr),
                .step (unit_p),
                .pulse(base_p)
            );
        end else begin : g_base_bypass
            assign base_p = unit_p;
        end
    endgenerate

    swd_post_cnt u_post (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .step  (base_p),
        .shift (shift),
        .expire(expire)
    );

    // Register the expiry into one-cycle reset and wake requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q  <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            rst_q  <= expire;
            wake_q <= expire & stop_mode;
        end
    end

    assign rst_req  = rst_q;
    assign wake_req = wake_q;
endmodule

// File: rtl/swd_chk.sv
// Module: property checker for slow_watchdog, attached through bind.
// Observes ports only.
module swd_chk (
    input logic clk,
    input logic rst_n,
    input logic slow_tick,
    input logic wd_on,
    input logic kick,
    input logic stop_mode,
    input logic rst_req,
    input logic wake_req
);
    // R3: the reset request never lasts two cycles.
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R5: a kick cycle never yields a request.
    assert_kick_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !rst_req);

    // R7: a disabled cycle never yields a request.
    assert_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_on |=> !rst_req);

    // R8: wake accompanies reset only when stop mode was high at expiry.
    assert_wake_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || wake_req) |-> (rst_req && (wake_req == $past(stop_mode))));

    // R9: expiry only follows a cycle that carried a tick.
    assert_tick_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !slow_tick |=> !rst_req);
endmodule

bind slow_watchdog swd_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow_tick(slow_tick),
    .wd_on    (wd_on),
    .kick     (kick),
    .stop_mode(stop_mode),
    .rst_req  (rst_req),
    .wake_req (wake_req)
);

// File: tb/sim_slow_watchdog.sv
// Bench: scoreboard for slow_watchdog. Driver tasks queue the cycle in
// which each request is due; a falling-edge monitor compares.
module sim_slow_watchdog;
    localparam int CLK_NS = 10;
    localparam int UNIT = 4;
    localparam int BASE = UNIT * 8;
    localparam int LIMIT = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b0;
    logic       wd_on = 1'b1;
    logic       kick = 1'b0;
    logic [2:0] ratio_sel = 3'b111;
    logic       stop_mode = 1'b0;
    logic       rst_req;
    logic       wake_req;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    int    q_cyc[$];
    bit    q_wk[$];
    string q_tag[$];

    // Ratio per code, indexed by code value (R1).
    int div_tab[8] = '{2048, 512, 128, 32, 8, 4, 2, 1};

    slow_watchdog #(.UNIT_TICKS(UNIT), .BASE_DIV(8)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_tick(slow_tick),
        .wd_on    (wd_on),
        .kick     (kick),
        .ratio_sel(ratio_sel),
        .stop_mode(stop_mode),
        .rst_req  (rst_req),
        .wake_req (wake_req)
    );

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: match each observed pulse against the queue head.
    always @(negedge clk) begin
        if (rst_n && q_cyc.size() > 0 && q_cyc[0] < cyc) begin
            total++; bad++;
            $display("FAIL %s: missing pulse, actual none expected at cycle %0d", q_tag[0], q_cyc[0]);
            void'(q_cyc.pop_front()); void'(q_wk.pop_front()); void'(q_tag.pop_front());
        end
        if (rst_n && (rst_req || wake_req)) begin
            total++;
            if (q_cyc.size() == 0) begin
                bad++;
                $display("FAIL R3: unexpected pulse at cycle %0d, actual rst=%0b wake=%0b expected none",
                         cyc, rst_req, wake_req);
            end else begin
                if (q_cyc[0] != cyc || !rst_req || wake_req != q_wk[0]) begin
                    bad++;
                    $display("FAIL %s: actual cycle=%0d rst=%0b wake=%0b expected cycle=%0d rst=1 wake=%0b",
                             q_tag[0], cyc, rst_req, wake_req, q_cyc[0], q_wk[0]);
                end
                void'(q_cyc.pop_front()); void'(q_wk.pop_front()); void'(q_tag.pop_front());
            end
        end
    end

    task automatic check_low(input string tag);
        total++;
        if (rst_req !== 1'b0 || wake_req !== 1'b0) begin
            bad++;
            $display("FAIL %s: actual rst=%0b wake=%0b expected 0 0", tag, rst_req, wake_req);
        end
    endtask

    // Drive n ticks with gap idle cycles after each; expect a pulse after
    // every `every`-th tick (0 = none) with wake flag wk.
    task automatic ticks(input int n, input int gap, input int every, input bit wk, input string tag);
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            slow_tick = 1'b1;
            if (every > 0 && (i % every) == 0) begin
                q_cyc.push_back(cyc + 1); q_wk.push_back(wk); q_tag.push_back(tag);
            end
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                slow_tick = 1'b0;
            end
        end
        @(negedge clk);
        slow_tick = 1'b0;
    endtask

    task automatic do_kick();
        @(negedge clk);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual no end expected end within %0d cycles", LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_low("R2");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_low("R2");

        // R2: first expiry from reset with code 111.
        ticks(BASE, 0, BASE, 1'b0, "R2");
        // R3: two periods back to back, one pulse each.
        ticks(2 * BASE, 0, BASE, 1'b0, "R3");

        // R1: every ratio code.
        for (int c = 7; c >= 0; c--) begin
            @(negedge clk);
            ratio_sel = 3'(c);
            do_kick();
            ticks(BASE * div_tab[c], 0, BASE * div_tab[c], 1'b0, "R1");
        end
        @(negedge clk);
        ratio_sel = 3'b111;

        // R4: kick mid-period restarts the full period.
        do_kick();
        ticks(20, 0, 0, 1'b0, "R4");
        do_kick();
        ticks(BASE, 0, BASE, 1'b0, "R4");

        // R5: kick in the same cycle as the expiring tick.
        do_kick();
        ticks(BASE - 1, 0, 0, 1'b0, "R5");
        @(negedge clk);
        slow_tick = 1'b1; kick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0; kick = 1'b0;
        ticks(BASE, 0, BASE, 1'b0, "R5");

        // R6: lowered ratio applies at the next base boundary.
        @(negedge clk);
        ratio_sel = 3'b100;
        do_kick();
        ticks(100, 0, 0, 1'b0, "R6");
        @(negedge clk);
        ratio_sel = 3'b111;
        ticks(28, 0, 28, 1'b0, "R6");
        // R6: raised ratio keeps the count already reached.
        do_kick();
        ticks(20, 0, 0, 1'b0, "R6");
        @(negedge clk);
        ratio_sel = 3'b110;
        ticks(44, 0, 44, 1'b0, "R6");
        @(negedge clk);
        ratio_sel = 3'b111;

        // R7: disabled: no count, kick ignored, restart from zero.
        @(negedge clk);
        wd_on = 1'b0;
        ticks(100, 0, 0, 1'b0, "R7");
        do_kick();
        @(negedge clk);
        wd_on = 1'b1;
        ticks(BASE, 0, BASE, 1'b0, "R7");
        ticks(20, 0, 0, 1'b0, "R7");
        @(negedge clk);
        wd_on = 1'b0;
        ticks(5, 0, 0, 1'b0, "R7");
        @(negedge clk);
        wd_on = 1'b1;
        ticks(BASE, 0, BASE, 1'b0, "R7");

        // R8: expiry in stop mode wakes; stop does not alter timing.
        do_kick();
        @(negedge clk);
        stop_mode = 1'b1;
        ticks(BASE, 0, BASE, 1'b1, "R8");
        do_kick();
        ticks(16, 0, 0, 1'b0, "R8");
        @(negedge clk);
        stop_mode = 1'b0;
        ticks(16, 0, 16, 1'b0, "R8");

        // R9: idle cycles between ticks do not count.
        do_kick();
        ticks(BASE, 3, BASE, 1'b0, "R9");

        repeat (5) @(negedge clk);
        total++;
        if (q_cyc.size() != 0) begin
            bad++;
            $display("FAIL R1: actual %0d pulses outstanding expected 0", q_cyc.size());
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule